// File: doc/BRIEF.md
# Shadowed-Register Pulse-Width Modulator with Update Lock

This block is a single-channel pulse-width modulator. Software sets it up through four 32-bit words reached over a simple synchronous port. A write is taken on the clock edge. A read returns data on the edge after the address is presented. Software writes a period count, a duty count and a control word. The control word carries the run bits, the output levels and an update lock.

The words that software writes are shadow copies. A free-running counter compares against a separate active set: period, duty and the two output levels. That active set is reloaded from the shadows only at fixed moments. These are the start of a run and each period rollover while the lock is clear. A waveform in progress is therefore never cut short. With the lock set, software can change period, duty and polarity in any order. All three then take effect together at the first rollover after the lock is released.

Top module: `pwm_lockreg`

## Requirements
- R1: After reset every register word reads 0 and `pwm_out` is 0.
- R2: `reg_addr` is a word index: 1 = period, 2 = duty, 3 = control. A write stores all 32 bits of `reg_wdata` in the selected word. Reading that word returns the stored value on `reg_rdata` one edge after the address is presented, whatever the lock state.
- R3: Word index 0 reads the live counter, sampled in the cycle the address is presented. Writes to index 0 change no register.
- R4: The modulator runs only while control bit 0 and control bit 1 are both 1. Otherwise the counter reads 0 and `pwm_out` equals control bit 4. This takes effect from the cycle after the control write.
- R5: On a control write that starts a run, the output still shows the idle level in the following cycle. The cycle after that is count 0 of a new period, built from the latest period, duty and control bits 3 and 4.
- R6: While running, the counter steps 0, 1, …, period−1 and wraps to 0. `pwm_out` equals control bit 3 while count < duty and control bit 4 otherwise. Normal polarity is bit 3 = 1, bit 4 = 0. Inverted polarity is bit 3 = 0, bit 4 = 1.
- R7: A duty of at least the period holds `pwm_out` at the bit-3 level for the whole run. A duty of 0 holds it at the bit-4 level.
- R8: With control bit 6 clear, period and duty written during a run take effect only at the next rollover. The period in progress finishes with its old length and duty.
- R9: While control bit 6 is set, rollovers keep the active period, duty and levels unchanged, so writes to them do not alter the waveform.
- R10: Once bit 6 is cleared, the pending period, duty and levels all take effect together at the first period start after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word index: 0 counter, 1 period, 2 duty, 3 control |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| pwm_out | output | 1 | Modulated output |

## Verification
Read data arrives one edge after the address. A counter read therefore shows the count of the cycle in which the address was driven. The bench compares a read taken k cycles into a run with (k−1) mod period.

A control write that starts a run shows the idle level on the next sampled cycle. Count 0 is due one cycle later. Waveform sampling starts exactly there.

Period and duty updates land only at rollovers, so the bench does not predict the cycle in which they take effect. It measures complete periods between rising edges of `pwm_out`. It skips the one period that may straddle the change, then compares length and high time. All sampling happens on the falling clock edge, or after a rising edge for the edge monitor, never on the edge that updates the design.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

  // control word bit positions
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_CONT = 1;
  localparam int unsigned CTL_DLVL = 3;
  localparam int unsigned CTL_ILVL = 4;
  localparam int unsigned CTL_LOCK = 6;

  // register word index
  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_CTL  = 2'd3
  } reg_sel_e;

  // output levels for the duty and the idle portion of a period
  typedef struct packed {
    logic dlvl;
    logic ilvl;
  } pol_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_live,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] period_sh,
  output logic [DATA_W-1:0] duty_sh,
  output logic              run_sh,
  output logic              lock_sh,
  output pol_t              pol_sh
);

  logic [DATA_W-1:0] ctrl_sh;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(addr);

  function automatic logic [DATA_W-1:0] f_read(
    input reg_sel_e          s,
    input logic [DATA_W-1:0] c,
    input logic [DATA_W-1:0] p,
    input logic [DATA_W-1:0] d,
    input logic [DATA_W-1:0] k
  );
    unique case (s)
      SEL_CNT:  return c;
      SEL_PER:  return p;
      SEL_DUTY: return d;
      default:  return k;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      period_sh <= '0;
      duty_sh   <= '0;
      ctrl_sh   <= '0;
    end else if (we) begin
      unique case (sel)
        SEL_PER:  period_sh <= wdata;
        SEL_DUTY: duty_sh   <= wdata;
        SEL_CTL:  ctrl_sh   <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= f_read(sel, cnt_live, period_sh, duty_sh, ctrl_sh);
  end

  assign run_sh      = ctrl_sh[CTL_EN] & ctrl_sh[CTL_CONT];
  assign lock_sh     = ctrl_sh[CTL_LOCK];
  assign pol_sh.dlvl = ctrl_sh[CTL_DLVL];
  assign pol_sh.ilvl = ctrl_sh[CTL_ILVL];

  // R3
  cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_CNT) |=> ($stable(period_sh) && $stable(duty_sh) && $stable(ctrl_sh)));

endmodule

// File: rtl/pwm_stage.sv
module pwm_stage
  import pwm_lock_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wrap,
  input  logic             live,
  input  logic             lock,
  input  logic [CNT_W-1:0] period_sh,
  input  logic [CNT_W-1:0] duty_sh,
  input  pol_t             pol_sh,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_duty,
  output pol_t             act_pol
);

  logic load_now;

  // fresh run always reloads; a rollover reloads only when unlocked
  assign load_now = start || (wrap && !lock);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_period <= '0;
      act_duty   <= '0;
      act_pol    <= '0;
    end else if (load_now) begin
      act_period <= period_sh;
      act_duty   <= duty_sh;
      act_pol    <= pol_sh;
    end
  end

  // R8
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !wrap) |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol)));

  // R9
  lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (live && lock) |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol)));

endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
  import pwm_lock_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             idle_sh,
  input  logic [CNT_W-1:0] act_period,
  input  logic [CNT_W-1:0] act_duty,
  input  pol_t             act_pol,
  output logic [CNT_W-1:0] cnt,
  output logic             start,
  output logic             wrap,
  output logic             live,
  output logic             pwm_out
);

  logic started;

  function automatic logic f_last(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return ({1'b0, c} + 1'b1) >= {1'b0, p};
  endfunction

  function automatic logic f_level(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] d,
                                   input pol_t pl);
    return (c < d) ? pl.dlvl : pl.ilvl;
  endfunction

  assign live  = run && started;
  assign start = run && !started;
  assign wrap  = live && f_last(cnt, act_period);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      started <= 1'b0;
    end else if (!started) begin
      cnt     <= '0;
      started <= 1'b1;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign pwm_out = live ? f_level(cnt, act_duty, act_pol) : idle_sh;

  // R4
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (live && act_period != '0) |-> (cnt < act_period));

  // R7
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (live && act_duty >= act_period) |-> (pwm_out == act_pol.dlvl));

endmodule

// File: rtl/pwm_lockreg.sv
module pwm_lockreg
  import pwm_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);

  localparam int CNT_W = DATA_W;

  logic [CNT_W-1:0] period_sh, duty_sh, act_period, act_duty, cnt;
  logic             run_sh, lock_sh, start, wrap, live;
  pol_t             pol_sh, act_pol;

  pwm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt_live(cnt), .rdata(reg_rdata), .period_sh(period_sh), .duty_sh(duty_sh),
    .run_sh(run_sh), .lock_sh(lock_sh), .pol_sh(pol_sh)
  );

  pwm_stage #(.CNT_W(CNT_W)) u_stage (
    .clk(clk), .rst(rst), .start(start), .wrap(wrap), .live(live), .lock(lock_sh),
    .period_sh(period_sh), .duty_sh(duty_sh), .pol_sh(pol_sh),
    .act_period(act_period), .act_duty(act_duty), .act_pol(act_pol)
  );

  pwm_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst), .run(run_sh), .idle_sh(pol_sh.ilvl),
    .act_period(act_period), .act_duty(act_duty), .act_pol(act_pol),
    .cnt(cnt), .start(start), .wrap(wrap), .live(live), .pwm_out(pwm_out)
  );

endmodule

// File: tb/sim_pwm_lockreg.sv
module sim_pwm_lockreg;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  // rising-edge monitor of pwm_out
  int n_rise = 0, rise_cyc = 0, hi_acc = 0, last_per = 0, last_hi = 0;
  logic prev_out = 1'b0;

  pwm_lockreg u0 (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
                  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 50000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (pwm_out && !prev_out) begin
        last_per = cyc - rise_cyc;
        last_hi  = hi_acc;
        rise_cyc = cyc;
        hi_acc   = 1;
        n_rise++;
      end else if (pwm_out) hi_acc++;
      prev_out = pwm_out;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_rise();
    int n0;
    @(posedge clk); n0 = n_rise;
    while (n_rise == n0) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(pwm_out == 1'b0, "R1 out", pwm_out, 0);
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], v);
      chk(v == 0, "R1 word", v, 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'h0000_00A5);
    wr(2'd3, 32'h0000_0160);
    rd(2'd1, v); chk(v == 32'h1234_5678, "R2 period", v, 32'h1234_5678);
    rd(2'd2, v); chk(v == 32'h0000_00A5, "R2 duty", v, 32'h0000_00A5);
    rd(2'd3, v); chk(v == 32'h0000_0160, "R2 control", v, 32'h0000_0160);
    // R3: write to counter word changes nothing
    wr(2'd0, 32'h0000_0055);
    rd(2'd0, v); chk(v == 0, "R3 counter idle", v, 0);
    rd(2'd1, v); chk(v == 32'h1234_5678, "R3 period untouched", v, 32'h1234_5678);
    rd(2'd3, v); chk(v == 32'h0000_0160, "R3 control untouched", v, 32'h0000_0160);
  endtask

  task automatic t_not_running();
    logic [31:0] v;
    int bad;
    wr(2'd1, 32'd6); wr(2'd2, 32'd2);
    wr(2'd3, 32'h11);  // enable only, idle high
    bad = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (pwm_out !== 1'b1) bad++; end
    chk(bad == 0, "R4 enable only idle high", bad, 0);
    rd(2'd0, v); chk(v == 0, "R4 counter held", v, 0);
    wr(2'd3, 32'h12);  // continuous only
    bad = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (pwm_out !== 1'b1) bad++; end
    chk(bad == 0, "R4 continuous only idle high", bad, 0);
    wr(2'd3, 32'h00);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R4 idle low", pwm_out, 0);
  endtask

  task automatic t_fresh_start();
    int bad_o, bad_c;
    wr(2'd1, 32'd10); wr(2'd2, 32'd3);
    wr(2'd3, 32'h0B);
    reg_addr = 2'd0;
    chk(pwm_out == 1'b0, "R5 idle before count 0", pwm_out, 0);
    bad_o = 0; bad_c = 0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (pwm_out !== ((k % 10) < 3)) bad_o++;
      if (k >= 1 && reg_rdata != ((k - 1) % 10)) begin
        bad_c++;
        $display("  counter at k=%0d read %0d", k, reg_rdata);
      end
    end
    chk(bad_o == 0, "R5 R6 waveform from count 0", bad_o, 0);
    chk(bad_c == 0, "R3 R6 live counter readback", bad_c, 0);
  endtask

  task automatic t_unlocked_update();
    wait_rise();
    repeat (3) @(negedge clk);
    wr(2'd2, 32'd2); wr(2'd1, 32'd4);
    wait_rise();
    chk(last_per == 10, "R8 old period completes", last_per, 10);
    chk(last_hi == 3, "R8 old duty completes", last_hi, 3);
    wait_rise();
    chk(last_per == 4 && last_hi == 2, "R8 new period and duty", last_per * 100 + last_hi, 402);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(2'd3, 32'h4B);
    wr(2'd1, 32'd7); wr(2'd2, 32'd5);
    rd(2'd1, v); chk(v == 7, "R2 R9 pending period readable", v, 7);
    for (int i = 0; i < 2; i++) begin
      wait_rise();
      chk(last_per == 4 && last_hi == 2, "R9 locked waveform unchanged",
          last_per * 100 + last_hi, 402);
    end
    wr(2'd3, 32'h0B);
    wait_rise();
    chk(last_per == 4 && last_hi == 2, "R10 period at release is old",
        last_per * 100 + last_hi, 402);
    wait_rise();
    chk(last_per == 7 && last_hi == 5, "R10 pending values applied",
        last_per * 100 + last_hi, 705);
  endtask

  task automatic t_lock_polarity();
    wr(2'd3, 32'h4B);
    wr(2'd3, 32'h53);  // locked, inverted pending
    wait_rise(); wait_rise();
    chk(last_per == 7 && last_hi == 5, "R9 polarity held while locked",
        last_per * 100 + last_hi, 705);
    wr(2'd3, 32'h13);
    wait_rise(); wait_rise(); wait_rise();
    chk(last_per == 7 && last_hi == 2, "R6 R10 inverted after release",
        last_per * 100 + last_hi, 702);
  endtask

  task automatic t_duty_extremes();
    int bad;
    wr(2'd3, 32'h00);
    wr(2'd1, 32'd5); wr(2'd2, 32'd9);
    wr(2'd3, 32'h0B);
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (pwm_out !== 1'b1) bad++; end
    chk(bad == 0, "R7 duty above period constant active", bad, 0);
    wr(2'd2, 32'd0);
    repeat (8) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (pwm_out !== 1'b0) bad++; end
    chk(bad == 0, "R7 duty zero constant inactive", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_not_running();
    t_fresh_start();
    t_unlocked_update();
    t_lock();
    t_lock_polarity();
    t_duty_extremes();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule